// File: doc/BRIEF.md
# Instruction-Count Fetch Thread Selector

This block decides, every cycle, which hardware thread of a simultaneous-multithreaded front end is allowed to fetch. For each thread it tracks how many instructions are in flight: the count rises by the number of instructions fetched for that thread and falls by the number retired or squashed. Among the threads that may fetch, the one with the smallest count wins. Ties are resolved by a rotating pointer that moves past the most recent fetcher.

A thread becomes unable to fetch for one of three reasons. It may be inactive. Its count may leave no room for a full-width fetch within its limit. Or it may be asleep on an address watch. When two or more threads are active, each one's limit is a cap set below the shared queue depth. A lone active thread may fill the whole queue.

A thread can arm a watch on a memory address and then quiesce. A later snooped write or invalidate to the same cache line wakes the thread and disarms the watch, and so does an interrupt to that thread. This replaces spinning on the location. If a matching snoop arrives before the quiesce, the watch is disarmed, so the quiesce has nothing to wait on and is dropped. No wakeup is lost this way.

Top module: `icf_fetch_sel`

## Requirements
- R1: After reset all counts are zero, no thread is armed or asleep, and the tie pointer is at thread 0, so with all threads active `sel_vld`=1 and `sel_tid`=0.
- R2: When `sel_vld` is 1, `sel_tid` is an eligible thread whose count is the smallest among the eligible threads.
- R3: Among eligible threads tied at the smallest count, the grant goes to the first one found scanning upward (with wrap) from the pointer. Each fetch event moves the pointer to one past `fch_tid`, wrapping to 0.
- R4: A thread's count changes in one cycle by +`fch_num` (fetch event for it), −`ret_num` (retire event for it) and −`sq_num` (squash event for it). The result is clamped at 0 and never wraps below it. A thread with no event keeps its count.
- R5: With two or more bits of `thr_active` set, a thread is eligible only if count + FETCH_W ≤ THR_CAP (defaults 4 and 12). With one active thread, the limit is QDEPTH (default 16).
- R6: A quiesce on a thread with an armed watch puts it to sleep from the next cycle, and it is not selected while asleep.
- R7: A quiesce on a thread with no armed watch has no effect; the thread stays selectable.
- R8: A snoop whose address equals the watched address in all bits above the low LINE_BITS (default 6, 64-byte lines) wakes a sleeping thread and disarms its watch. A snoop to another line has no effect.
- R9: A matching snoop seen before the quiesce disarms the watch, so that quiesce is dropped. A quiesce and a matching snoop in the same cycle leave the thread awake.
- R10: An `irq` bit set for a sleeping thread wakes it from the next cycle.
- R11: If no thread is eligible, `sel_vld` is 0 and `sel_tid` is 0.
- R12: A thread whose `thr_active` bit is 0 is never selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| thr_active | input | NTHR | Threads that hold a running context |
| fch_en | input | 1 | Fetch event this cycle |
| fch_tid | input | TID_W | Thread that fetched |
| fch_num | input | NUM_W | Instructions fetched |
| ret_en | input | 1 | Retire event this cycle |
| ret_tid | input | TID_W | Thread that retired |
| ret_num | input | NUM_W | Instructions retired |
| sq_en | input | 1 | Squash event this cycle |
| sq_tid | input | TID_W | Thread that was squashed |
| sq_num | input | CNT_W | Instructions squashed |
| arm_en | input | 1 | Load-and-watch: arm a watch |
| arm_tid | input | TID_W | Thread arming the watch |
| arm_addr | input | ADDR_W | Address to watch |
| qui_en | input | 1 | Quiesce request |
| qui_tid | input | TID_W | Thread to quiesce |
| snp_en | input | 1 | Snooped write or invalidate |
| snp_addr | input | ADDR_W | Snooped address |
| irq | input | NTHR | Per-thread interrupt wake |
| sel_vld | output | 1 | A thread is granted fetch |
| sel_tid | output | TID_W | Granted thread |
| thr_cnt | output | NTHR*CNT_W | In-flight count per thread, thread i at bits i*CNT_W |

## Verification
Two functions can land in the same cycle: a quiesce request and a snooped write to the very line being watched. The bench arms a watch and then raises the quiesce and the matching snoop on the same edge. It passes only if the thread is still granted fetch on the next cycle and a later quiesce is still ignored. A second collision puts a fetch, a retire and a squash for one thread on the same edge. It is judged by the reported count, including the case where the decrements exceed the count plus the increment.

// File: rtl/icf_pkg.sv
package icf_pkg;
  // Address-watch state for one thread
  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_ARMED = 2'd1,
    WS_SLEEP = 2'd2
  } wstate_e;
endpackage

// File: rtl/icf_inflight.sv
module icf_inflight #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5,
  parameter int NUM_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_W-1:0] inc,
  input  logic [NUM_W-1:0] ret,
  input  logic [CNT_W-1:0] sq,
  output logic [CNT_W-1:0] cnt
);
  localparam int SUM_W = CNT_W + 2;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SUM_W-1:0] up_w, down_w, diff_w;
  logic             upd;

  always_comb begin
    up_w   = SUM_W'(cnt_q) + SUM_W'(inc);
    down_w = SUM_W'(ret) + SUM_W'(sq);
    if (up_w > down_w) diff_w = up_w - down_w;
    else               diff_w = '0;
    if (diff_w > SUM_W'(DEPTH)) cnt_d = CNT_W'(DEPTH);
    else                        cnt_d = diff_w[CNT_W-1:0];
    upd = (inc != '0) || (ret != '0) || (sq != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (upd) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH)); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((SUM_W'(ret) + SUM_W'(sq)) >= (SUM_W'(cnt) + SUM_W'(inc))) |=> (cnt == '0)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (inc == '0 && ret == '0 && sq == '0) |=> $stable(cnt)); // R4
endmodule

// File: rtl/icf_watch.sv
module icf_watch
  import icf_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LINE_BITS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [ADDR_W-1:0] arm_addr,
  input  logic              qui,
  input  logic              snp_en,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              irq,
  output logic              asleep
);
  localparam logic [ADDR_W-1:0] LINE_MASK =
    {{(ADDR_W-LINE_BITS){1'b1}}, {LINE_BITS{1'b0}}};

  wstate_e           st_q, st_d;
  logic [ADDR_W-1:0] wa_q;
  logic              hit;

  always_comb begin
    hit  = snp_en && (st_q != WS_IDLE) && (((snp_addr ^ wa_q) & LINE_MASK) == '0);
    st_d = st_q;
    if (arm)                              st_d = WS_ARMED;
    else if (hit)                         st_d = WS_IDLE;
    else if (st_q == WS_SLEEP && irq)     st_d = WS_IDLE;
    else if (st_q == WS_ARMED && qui && !irq) st_d = WS_SLEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= WS_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   wa_q <= '0;
    else if (arm) wa_q <= arm_addr;
  end

  assign asleep = (st_q == WS_SLEEP);

  AST_QUI_SLEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WS_ARMED && qui && !hit && !irq && !arm) |=> asleep); // R6
  AST_NO_ARM_NO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WS_IDLE && !arm) |=> !asleep); // R7
  AST_WAKE_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_en && asleep && (((snp_addr ^ wa_q) & LINE_MASK) == '0)) |=> !asleep); // R8
  AST_IRQ_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && irq) |=> !asleep); // R10
endmodule

// File: rtl/icf_pick.sv
module icf_pick #(
  parameter int NTHR  = 4,
  parameter int CNT_W = 5,
  parameter int TID_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NTHR-1:0]       elig,
  input  logic [NTHR*CNT_W-1:0] cnt_flat,
  input  logic [TID_W-1:0]      rr,
  output logic                  sel_vld,
  output logic [TID_W-1:0]      sel_tid
);
  logic [CNT_W-1:0] minv;
  logic [NTHR-1:0]  tie;

  always_comb begin
    minv = '1;
    for (int i = 0; i < NTHR; i++) begin
      if (elig[i] && (cnt_flat[i*CNT_W +: CNT_W] < minv))
        minv = cnt_flat[i*CNT_W +: CNT_W];
    end
    for (int i = 0; i < NTHR; i++) begin
      tie[i] = elig[i] && (cnt_flat[i*CNT_W +: CNT_W] == minv);
    end
  end

  // Scan downward in offset so that the smallest offset from rr wins.
  always_comb begin
    sel_vld = 1'b0;
    sel_tid = '0;
    for (int k = NTHR - 1; k >= 0; k--) begin
      int j;
      j = int'(rr) + k;
      if (j >= NTHR) j = j - NTHR;
      if (tie[j]) begin
        sel_vld = 1'b1;
        sel_tid = TID_W'(j);
      end
    end
  end

  AST_SEL_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
    sel_vld |-> elig[sel_tid]); // R2
  AST_IDLE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_vld |-> (elig == '0 && sel_tid == '0)); // R11
  AST_SOME_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (elig != '0) |-> sel_vld); // R2
endmodule

// File: rtl/icf_fetch_sel.sv
module icf_fetch_sel #(
  parameter int NTHR      = 4,
  parameter int QDEPTH    = 16,
  parameter int THR_CAP   = 12,
  parameter int FETCH_W   = 4,
  parameter int ADDR_W    = 32,
  parameter int LINE_BITS = 6,
  localparam int TID_W    = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int CNT_W    = $clog2(QDEPTH + 1),
  localparam int NUM_W    = $clog2(FETCH_W + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NTHR-1:0]       thr_active,
  input  logic                  fch_en,
  input  logic [TID_W-1:0]      fch_tid,
  input  logic [NUM_W-1:0]      fch_num,
  input  logic                  ret_en,
  input  logic [TID_W-1:0]      ret_tid,
  input  logic [NUM_W-1:0]      ret_num,
  input  logic                  sq_en,
  input  logic [TID_W-1:0]      sq_tid,
  input  logic [CNT_W-1:0]      sq_num,
  input  logic                  arm_en,
  input  logic [TID_W-1:0]      arm_tid,
  input  logic [ADDR_W-1:0]     arm_addr,
  input  logic                  qui_en,
  input  logic [TID_W-1:0]      qui_tid,
  input  logic                  snp_en,
  input  logic [ADDR_W-1:0]     snp_addr,
  input  logic [NTHR-1:0]       irq,
  output logic                  sel_vld,
  output logic [TID_W-1:0]      sel_tid,
  output logic [NTHR*CNT_W-1:0] thr_cnt
);
  // Reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  logic [CNT_W-1:0] cnt_a [NTHR];
  logic [NTHR-1:0]  sleep_v;
  logic [NTHR-1:0]  elig;
  logic [TID_W-1:0] rr_q, rr_d;

  for (genvar i = 0; i < NTHR; i++) begin : g_thr
    logic [NUM_W-1:0] inc_i, ret_i;
    logic [CNT_W-1:0] sq_i;

    assign inc_i = (fch_en && fch_tid == TID_W'(i)) ? fch_num : '0;
    assign ret_i = (ret_en && ret_tid == TID_W'(i)) ? ret_num : '0;
    assign sq_i  = (sq_en  && sq_tid  == TID_W'(i)) ? sq_num  : '0;

    icf_inflight #(.DEPTH(QDEPTH), .CNT_W(CNT_W), .NUM_W(NUM_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_ni),
      .inc   (inc_i),
      .ret   (ret_i),
      .sq    (sq_i),
      .cnt   (cnt_a[i])
    );

    icf_watch #(.ADDR_W(ADDR_W), .LINE_BITS(LINE_BITS)) u_watch (
      .clk      (clk),
      .rst_n    (rst_ni),
      .arm      (arm_en && arm_tid == TID_W'(i)),
      .arm_addr (arm_addr),
      .qui      (qui_en && qui_tid == TID_W'(i)),
      .snp_en   (snp_en),
      .snp_addr (snp_addr),
      .irq      (irq[i]),
      .asleep   (sleep_v[i])
    );

    assign thr_cnt[i*CNT_W +: CNT_W] = cnt_a[i];
  end

  // Eligibility: active, awake, and room for a full-width fetch
  always_comb begin
    int lim;
    lim = ($countones(thr_active) > 1) ? THR_CAP : QDEPTH;
    for (int i = 0; i < NTHR; i++) begin
      elig[i] = thr_active[i] && !sleep_v[i] && ((int'(cnt_a[i]) + FETCH_W) <= lim);
    end
  end

  // Tie pointer moves past the thread that last fetched
  always_comb begin
    rr_d = rr_q;
    if (fch_en) begin
      if (fch_tid == TID_W'(NTHR - 1)) rr_d = '0;
      else                             rr_d = fch_tid + TID_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     rr_q <= '0;
    else if (fch_en) rr_q <= rr_d;
  end

  icf_pick #(.NTHR(NTHR), .CNT_W(CNT_W), .TID_W(TID_W)) u_pick (
    .clk      (clk),
    .rst_n    (rst_ni),
    .elig     (elig),
    .cnt_flat (thr_cnt),
    .rr       (rr_q),
    .sel_vld  (sel_vld),
    .sel_tid  (sel_tid)
  );

  AST_CAP_MULTI: assert property (@(posedge clk) disable iff (!rst_ni)
    (sel_vld && $countones(thr_active) > 1) |->
      ((int'(thr_cnt[sel_tid*CNT_W +: CNT_W]) + FETCH_W) <= THR_CAP)); // R5
  AST_INACTIVE: assert property (@(posedge clk) disable iff (!rst_ni)
    sel_vld |-> thr_active[sel_tid]); // R12
  AST_ASLEEP_OUT: assert property (@(posedge clk) disable iff (!rst_ni)
    sel_vld |-> !sleep_v[sel_tid]); // R6
endmodule

// File: tb/icf_fetch_sel_bench.sv
module icf_fetch_sel_bench;
  localparam int NTHR = 4;
  localparam int CW   = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  thr_active;
  logic        fch_en, ret_en, sq_en, arm_en, qui_en, snp_en;
  logic [1:0]  fch_tid, ret_tid, sq_tid, arm_tid, qui_tid;
  logic [2:0]  fch_num, ret_num;
  logic [4:0]  sq_num;
  logic [31:0] arm_addr, snp_addr;
  logic [3:0]  irq;
  logic        sel_vld;
  logic [1:0]  sel_tid;
  logic [19:0] thr_cnt;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [31:0] WADDR = 32'h1000_0040;

  always #4 clk = ~clk;

  icf_fetch_sel u_icf_fetch_sel (
    .clk(clk), .rst_n(rst_n), .thr_active(thr_active),
    .fch_en(fch_en), .fch_tid(fch_tid), .fch_num(fch_num),
    .ret_en(ret_en), .ret_tid(ret_tid), .ret_num(ret_num),
    .sq_en(sq_en), .sq_tid(sq_tid), .sq_num(sq_num),
    .arm_en(arm_en), .arm_tid(arm_tid), .arm_addr(arm_addr),
    .qui_en(qui_en), .qui_tid(qui_tid),
    .snp_en(snp_en), .snp_addr(snp_addr), .irq(irq),
    .sel_vld(sel_vld), .sel_tid(sel_tid), .thr_cnt(thr_cnt)
  );

  task automatic clr();
    fch_en = 0; fch_tid = 0; fch_num = 0;
    ret_en = 0; ret_tid = 0; ret_num = 0;
    sq_en = 0; sq_tid = 0; sq_num = 0;
    arm_en = 0; arm_tid = 0; arm_addr = 0;
    qui_en = 0; qui_tid = 0;
    snp_en = 0; snp_addr = 0; irq = 0;
  endtask

  // One edge, then sample 2 ns later, then clear the pulses
  task automatic cyc();
    @(posedge clk);
    #2;
    clr();
  endtask

  task automatic chk_sel(input logic ev, input logic [1:0] et, input string req);
    n_chk++;
    if (sel_vld !== ev || (ev && sel_tid !== et) || (!ev && sel_tid !== 2'd0)) begin
      n_bad++;
      $display("FAIL %s: sel vld/tid = %0b/%0d, expected %0b/%0d", req, sel_vld, sel_tid, ev, ev ? et : 2'd0);
    end
  endtask

  task automatic chk_cnt(input int t, input int exp, input string req);
    n_chk++;
    if (int'(thr_cnt[t*CW +: CW]) != exp) begin
      n_bad++;
      $display("FAIL %s: thread %0d count = %0d, expected %0d", req, t, thr_cnt[t*CW +: CW], exp);
    end
  endtask

  task automatic fetch(input int t, input int n);
    fch_en = 1; fch_tid = 2'(t); fch_num = 3'(n);
    cyc();
  endtask

  task automatic drain();
    for (int t = 0; t < NTHR; t++) begin
      sq_en = 1; sq_tid = 2'(t); sq_num = 5'd31;
      cyc();
    end
  endtask

  task automatic t_reset();
    chk_sel(1'b1, 2'd0, "R1");
    for (int t = 0; t < NTHR; t++) chk_cnt(t, 0, "R1");
  endtask

  task automatic t_pick();
    fetch(0, 3); chk_sel(1'b1, 2'd1, "R3");
    fetch(1, 2); chk_sel(1'b1, 2'd2, "R3");
    fetch(2, 1); chk_sel(1'b1, 2'd3, "R2");
    fetch(3, 4); chk_sel(1'b1, 2'd2, "R2");   // counts 3,2,1,4
    fetch(2, 1); chk_sel(1'b1, 2'd1, "R3");   // 3,2,2,4 ptr 3 -> t1
  endtask

  task automatic t_count();
    fch_en = 1; fch_tid = 0; fch_num = 2;
    ret_en = 1; ret_tid = 0; ret_num = 1;
    sq_en = 1; sq_tid = 0; sq_num = 1;
    cyc(); chk_cnt(0, 3, "R4");
    ret_en = 1; ret_tid = 2; ret_num = 4;
    cyc(); chk_cnt(2, 0, "R4");
    fch_en = 1; fch_tid = 1; fch_num = 1;
    sq_en = 1; sq_tid = 1; sq_num = 10;
    cyc(); chk_cnt(1, 0, "R4");
    chk_cnt(3, 4, "R4");
    drain();
  endtask

  task automatic t_cap();
    thr_active = 4'b0011;
    fetch(0, 4); fetch(0, 4);
    fetch(1, 4); fetch(1, 4); fetch(1, 2);     // 8, 10
    chk_sel(1'b1, 2'd0, "R5");
    fetch(0, 1);                               // 9, 10
    chk_sel(1'b0, 2'd0, "R11");
    thr_active = 4'b0001;
    #1; chk_sel(1'b1, 2'd0, "R5");
    fetch(0, 4);                               // 13
    chk_sel(1'b0, 2'd0, "R5");
    drain();
    thr_active = 4'b1111;
  endtask

  task automatic t_inactive();
    thr_active = 4'b1010;                      // ptr at 1
    #1; chk_sel(1'b1, 2'd1, "R12");
    thr_active = 4'b1000;
    #1; chk_sel(1'b1, 2'd3, "R12");
    thr_active = 4'b1111;
    #1;
  endtask

  task automatic t_quiesce();
    fetch(1, 1); fetch(2, 1); fetch(3, 1);     // 0,1,1,1 ptr 0
    chk_sel(1'b1, 2'd0, "R2");
    qui_en = 1; qui_tid = 0;
    cyc(); chk_sel(1'b1, 2'd0, "R7");
    arm_en = 1; arm_tid = 0; arm_addr = WADDR;
    cyc(); chk_sel(1'b1, 2'd0, "R6");
    qui_en = 1; qui_tid = 0;
    cyc(); chk_sel(1'b1, 2'd1, "R6");
    snp_en = 1; snp_addr = WADDR + 32'h40;
    cyc(); chk_sel(1'b1, 2'd1, "R8");
    snp_en = 1; snp_addr = WADDR + 32'h3C;
    cyc(); chk_sel(1'b1, 2'd0, "R8");
  endtask

  task automatic t_race();
    arm_en = 1; arm_tid = 0; arm_addr = WADDR;
    cyc();
    snp_en = 1; snp_addr = WADDR + 32'h4;
    cyc();
    qui_en = 1; qui_tid = 0;
    cyc(); chk_sel(1'b1, 2'd0, "R9");
    arm_en = 1; arm_tid = 0; arm_addr = WADDR;
    cyc();
    qui_en = 1; qui_tid = 0; snp_en = 1; snp_addr = WADDR + 32'h8;
    cyc(); chk_sel(1'b1, 2'd0, "R9");
    qui_en = 1; qui_tid = 0;
    cyc(); chk_sel(1'b1, 2'd0, "R9");
  endtask

  task automatic t_irq();
    arm_en = 1; arm_tid = 0; arm_addr = WADDR;
    cyc();
    qui_en = 1; qui_tid = 0;
    cyc(); chk_sel(1'b1, 2'd1, "R6");
    cyc(); chk_sel(1'b1, 2'd1, "R6");
    irq = 4'b0001;
    cyc(); chk_sel(1'b1, 2'd0, "R10");
  endtask

  initial begin
    #(8 * 20000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    clr();
    thr_active = 4'b1111;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (4) @(posedge clk);
    #2;
    t_reset();
    t_pick();
    t_count();
    t_cap();
    t_inactive();
    t_quiesce();
    t_race();
    t_irq();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule